// File: doc/BRIEF.md
# Five-Level Staircase Activation Quantiser

This block sits below one column of a synapse array. It turns the signed activity total gathered down that column into one of five neuron states: full negative, half negative, zero, half positive and full positive. The state goes back onto the state bus as a three-flag code. The mapping is a staircase that approximates a sigmoid, centred on a programmable threshold. A programmable temperature sets the width of the intermediate steps. When the temperature is zero, the staircase becomes a plain two-level sign decision about the threshold.

Each result is captured on the clock edge where the input strobe is high. The result appears one cycle later, together with a one-cycle valid flag, and stays on the output until the next strobe.

The breakpoints lie at half the temperature on each side of the threshold, always rounded down. The outer breakpoints depend on the elaboration-time parameter `WIDE_STEPS`. By default they lie at the temperature itself. With `WIDE_STEPS` set, they lie at the temperature plus half the temperature.

Top module: `stair_quantiser`

## Requirements
- R1: The state code has three flags: bit 2 means negate, bit 1 means halve, and bit 0 means zero. The five levels are encoded as follows: +1 = 3'b000, +0.5 = 3'b010, 0 = 3'b001, -0.5 = 3'b110, -1 = 3'b100. No other code is ever produced.
- R2: Let d = activity - threshold, with both values signed, and let h = floor(T/2). With the default breakpoints, the result is:
  - +1 when d >= T
  - +0.5 when h <= d < T
  - 0 when -h <= d < h
  - -0.5 when -T <= d < -h
  - -1 when d < -T
- R3: An activity that falls exactly on a breakpoint takes the higher of the two neighbouring levels.
- R4: When the temperature is zero, only +1 and -1 occur. The result is +1 when activity >= threshold and -1 otherwise.
- R5: An activity at or above the threshold never gives a negative level. An activity below the threshold never gives +1.
- R6: When in_valid is high at a clock edge, state_code shows the result for the inputs of that edge immediately after that edge. out_valid is high for exactly the cycle that follows each strobe.
- R7: When in_valid is low, state_code holds its previous value whatever the data inputs do, and out_valid is low.
- R8: The comparisons are exact over the whole input range. This includes activity and threshold at -32768 and +32767 with the largest temperature.
- R9: During and after a synchronous active-low reset, out_valid is 0 and state_code is the zero level 3'b001.
- R10: With `WIDE_STEPS` = 1, the outer breakpoints move to ±(T + floor(T/2)). The levels and the tie rule stay the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: capture the current activity |
| activity | input | ACT_W (16) | Signed column activity total |
| threshold | input | ACT_W (16) | Signed centre of the staircase |
| temperature | input | TEMP_W (15) | Unsigned step-width control |
| out_valid | output | 1 | High for one cycle after each strobe |
| state_code | output | 3 | Registered neuron state flags {negate, halve, zero} |

## Verification
The assertions assume that in_valid, activity, threshold and temperature are known, non-X values on every clock edge after reset. The sign and hard-threshold properties compare the data inputs only on cycles where the strobe is high, so they assume those inputs are held steady across the capturing edge. The stimulus satisfies these assumptions by driving every input on the falling edge and keeping all of them at defined values from time zero. Random activity is drawn close to a random threshold and clamped into the 16-bit range, and random temperatures are kept small so that all five levels occur often. Directed vectors then cover the exact breakpoints and the range extremes.

// File: rtl/stair_pkg.sv
// stair_pkg: shared state-code encoding for the staircase quantiser.
// Assumes a three-flag code {negate, halve, zero}; the zero flag excludes the others.
package stair_pkg;

    typedef enum logic [2:0] {
        ST_POS_FULL = 3'b000,
        ST_POS_HALF = 3'b010,
        ST_ZERO     = 3'b001,
        ST_NEG_HALF = 3'b110,
        ST_NEG_FULL = 3'b100
    } state_code_t;

    // Number of breakpoints splitting the range into five levels.
    localparam int unsigned NUM_BREAKS = 4;

    // Maps how many breakpoints the activity has reached (0..4) to a state code.
    function automatic state_code_t level_from_count(input logic [2:0] reached);
        state_code_t code;
        case (reached)
            3'd0:    code = ST_NEG_FULL;
            3'd1:    code = ST_NEG_HALF;
            3'd2:    code = ST_ZERO;
            3'd3:    code = ST_POS_HALF;
            default: code = ST_POS_FULL;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/stair_breakpoints.sv
// stair_breakpoints: derives the inner and outer breakpoint offsets from the temperature.
// Assumes the temperature is unsigned; inner = floor(T/2); outer = T, or T + floor(T/2)
// when WIDE selects the wider variant. Outputs are unsigned and never overflow BP_W.
module stair_breakpoints #(
    parameter int unsigned TEMP_W = 15,
    parameter bit          WIDE   = 1'b0,
    localparam int unsigned BP_W  = TEMP_W + 1
) (
    input  logic [TEMP_W-1:0] temperature,
    output logic [BP_W-1:0]   inner_off,
    output logic [BP_W-1:0]   outer_off
);

    logic [BP_W-1:0] temp_ext;

    // Widen the temperature so the wide variant sum fits.
    always_comb temp_ext = {1'b0, temperature};

    // Inner offset: half the temperature, rounded down.
    always_comb inner_off = temp_ext >> 1;

    generate
        if (WIDE) begin : g_wide
            // Outer offset: one and a half times the temperature.
            always_comb outer_off = temp_ext + (temp_ext >> 1);
        end else begin : g_narrow
            // Outer offset: the temperature itself.
            always_comb outer_off = temp_ext;
        end
    endgenerate

endmodule

// File: rtl/stair_compare.sv
// stair_compare: forms activity - threshold at full precision and compares it with
// the four signed breakpoints. Produces a thermometer vector, bit k set when the
// difference is at or above breakpoint k (ordered -outer, -inner, +inner, +outer).
// Assumes inner_off <= outer_off, so the vector is always a thermometer.
module stair_compare #(
    parameter int unsigned ACT_W  = 16,
    parameter int unsigned BP_W   = 16,
    localparam int unsigned CMP_W = ((ACT_W > BP_W) ? ACT_W : BP_W) + 2
) (
    input  logic [ACT_W-1:0] activity,
    input  logic [ACT_W-1:0] threshold,
    input  logic [BP_W-1:0]  inner_off,
    input  logic [BP_W-1:0]  outer_off,
    output logic [3:0]       reached
);

    logic signed [CMP_W-1:0] diff;
    logic signed [CMP_W-1:0] inner_s;
    logic signed [CMP_W-1:0] outer_s;
    logic signed [CMP_W-1:0] bp [4];

    // Sign-extend both operands, then subtract; two guard bits rule out overflow.
    always_comb diff = CMP_W'($signed(activity)) - CMP_W'($signed(threshold));

    // Zero-extend the unsigned offsets into the signed comparison width.
    always_comb begin
        inner_s = $signed({{(CMP_W-BP_W){1'b0}}, inner_off});
        outer_s = $signed({{(CMP_W-BP_W){1'b0}}, outer_off});
    end

    // Breakpoints listed in ascending order.
    always_comb begin
        bp[0] = -outer_s;
        bp[1] = -inner_s;
        bp[2] = inner_s;
        bp[3] = outer_s;
    end

    generate
        for (genvar k = 0; k < 4; k++) begin : g_cmp
            // Ties resolve upward: reaching the breakpoint counts as passing it.
            always_comb reached[k] = (diff >= bp[k]);
        end
    endgenerate

endmodule

// File: rtl/stair_encode.sv
// stair_encode: turns the thermometer of reached breakpoints into the state code.
// Assumes a well-formed thermometer; the count of set bits selects the level.
module stair_encode
    import stair_pkg::*;
(
    input  logic [3:0]  reached,
    output state_code_t code
);

    logic [2:0] count;

    // Count how many breakpoints the activity has reached.
    always_comb count = 3'($countones(reached));

    // Look up the level for that count.
    always_comb code = level_from_count(count);

endmodule

// File: rtl/stair_quantiser.sv
// stair_quantiser: five-level staircase activation for one synapse column.
// Captures the level on each in_valid edge and holds it until the next strobe;
// out_valid pulses for the cycle after each strobe. Synchronous active-low reset
// leaves the zero level on the output. WIDE_STEPS selects the outer breakpoint spacing.
module stair_quantiser
    import stair_pkg::*;
#(
    parameter int unsigned ACT_W      = 16,
    parameter int unsigned TEMP_W     = ACT_W - 1,
    parameter bit          WIDE_STEPS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ACT_W-1:0]  activity,
    input  logic [ACT_W-1:0]  threshold,
    input  logic [TEMP_W-1:0] temperature,
    output logic              out_valid,
    output logic [2:0]        state_code
);

    localparam int unsigned BP_W = TEMP_W + 1;

    logic [BP_W-1:0] inner_off;
    logic [BP_W-1:0] outer_off;
    logic [3:0]      reached;
    state_code_t     next_code;
    state_code_t     code_q;
    logic            valid_q;

    stair_breakpoints #(
        .TEMP_W (TEMP_W),
        .WIDE   (WIDE_STEPS)
    ) u_breakpoints (
        .temperature (temperature),
        .inner_off   (inner_off),
        .outer_off   (outer_off)
    );

    stair_compare #(
        .ACT_W (ACT_W),
        .BP_W  (BP_W)
    ) u_compare (
        .activity  (activity),
        .threshold (threshold),
        .inner_off (inner_off),
        .outer_off (outer_off),
        .reached   (reached)
    );

    stair_encode u_encode (
        .reached (reached),
        .code    (next_code)
    );

    // Output register: load the new level on a strobe, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= ST_ZERO;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                code_q <= next_code;
            end
        end
    end

    // Drive the ports from the registers.
    always_comb begin
        state_code = code_q;
        out_valid  = valid_q;
    end

endmodule

// File: rtl/stair_quantiser_checker.sv
// stair_quantiser_checker: temporal properties of the quantiser ports, bound to every
// instance. Assumes inputs are known and held steady across each capturing edge.
module stair_quantiser_checker #(
    parameter int unsigned ACT_W  = 16,
    parameter int unsigned TEMP_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ACT_W-1:0]  activity,
    input logic [ACT_W-1:0]  threshold,
    input logic [TEMP_W-1:0] temperature,
    input logic              out_valid,
    input logic [2:0]        state_code
);

    // R1: the zero flag never appears together with negate or halve.
    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_code[0] |-> (state_code[2:1] == 2'b00));

    // R6: a strobe is followed by out_valid on the next cycle.
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: without a strobe, out_valid drops and the code holds.
    a_r7_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(state_code)));

    // R4: zero temperature yields only the full levels.
    a_r4_hard_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && temperature == '0) |=> (state_code[1:0] == 2'b00));

    // R5: at or above threshold never gives a negative level.
    a_r5_no_negative_above: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ($signed(activity) >= $signed(threshold))) |=> !state_code[2]);

    // R5: below threshold never gives the full positive level.
    a_r5_no_full_below: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ($signed(activity) < $signed(threshold))) |=> (state_code != 3'b000));

endmodule

bind stair_quantiser stair_quantiser_checker #(
    .ACT_W  (ACT_W),
    .TEMP_W (TEMP_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .activity    (activity),
    .threshold   (threshold),
    .temperature (temperature),
    .out_valid   (out_valid),
    .state_code  (state_code)
);

// File: tb/stair_quantiser_bench.sv
module stair_quantiser_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ACT_W      = 16;
    localparam int TEMP_W     = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ACT_W-1:0]  activity = '0;
    logic [ACT_W-1:0]  threshold = '0;
    logic [TEMP_W-1:0] temperature = '0;
    logic              out_valid;
    logic [2:0]        state_code;
    logic              out_valid_w;
    logic [2:0]        state_code_w;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stair_quantiser #(.ACT_W(ACT_W), .TEMP_W(TEMP_W), .WIDE_STEPS(1'b0)) u_stair_quantiser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .activity(activity),
        .threshold(threshold), .temperature(temperature),
        .out_valid(out_valid), .state_code(state_code));

    stair_quantiser #(.ACT_W(ACT_W), .TEMP_W(TEMP_W), .WIDE_STEPS(1'b1)) u_stair_quantiser_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .activity(activity),
        .threshold(threshold), .temperature(temperature),
        .out_valid(out_valid_w), .state_code(state_code_w));

    // Expected level from R1/R2/R3/R10, using plain integer arithmetic.
    function automatic logic [2:0] expect_code(int act, int thr, int t, bit wide);
        int d, h, o;
        d = act - thr;
        h = t / 2;
        o = wide ? (t + h) : t;
        if (d >= o)       return 3'b000;
        else if (d >= h)  return 3'b010;
        else if (d >= -h) return 3'b001;
        else if (d >= -o) return 3'b110;
        else              return 3'b100;
    endfunction

    task automatic check(string req, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Apply one strobe and check both instances one edge later (R6).
    task automatic apply(string req, int act, int thr, int t);
        @(negedge clk);
        activity    = ACT_W'(act);
        threshold   = ACT_W'(thr);
        temperature = TEMP_W'(t);
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " narrow"}, state_code, expect_code(act, thr, t, 1'b0));
        check({req, " wide"}, state_code_w, expect_code(act, thr, t, 1'b1));
        check("R6 out_valid pulse", {2'b00, out_valid}, 3'b001);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R9: reset state.
        check("R9 reset code", state_code, 3'b001);
        check("R9 reset valid", {2'b00, out_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after reset", state_code, 3'b001);

        // R2/R3: every level and every tie, T = 100, threshold 0 (R1 codes).
        apply("R2 +1", 150, 0, 100);
        apply("R3 tie outer", 100, 0, 100);
        apply("R2 +0.5", 99, 0, 100);
        apply("R3 tie inner", 50, 0, 100);
        apply("R2 zero", 49, 0, 100);
        apply("R3 tie -inner", -50, 0, 100);
        apply("R2 -0.5", -51, 0, 100);
        apply("R3 tie -outer", -100, 0, 100);
        apply("R2 -1", -101, 0, 100);
        // R10: wide breakpoints at +/-150.
        apply("R10 below wide outer", 1149, 1000, 100);
        apply("R10 wide outer tie", 1150, 1000, 100);
        apply("R10 wide -outer tie", 850, 1000, 100);
        apply("R10 wide beyond", 849, 1000, 100);
        // R4: zero temperature.
        apply("R4 at threshold", -300, -300, 0);
        apply("R4 just below", -301, -300, 0);
        apply("R4 far above", 20000, -300, 0);
        // R5: odd temperature, threshold side.
        apply("R5 just below T=1", 499, 500, 1);
        apply("R5 at threshold T=1", 500, 500, 1);
        // R8: extremes.
        apply("R8 max minus min", 32767, -32768, 32767);
        apply("R8 min minus max", -32768, 32767, 32767);
        apply("R8 equal max", 32767, 32767, 32767);
        apply("R8 min at zero thr", -32768, 0, 32767);

        // R7: hold while the strobe is low.
        apply("R7 load", 400, 0, 100);
        @(negedge clk);
        activity = ACT_W'(-5000);
        @(negedge clk);
        check("R7 code held", state_code, 3'b000);
        check("R7 wide held", state_code_w, 3'b000);
        check("R7 valid low", {2'b00, out_valid}, 3'b000);

        // Random vectors near a random threshold.
        for (int i = 0; i < 3000; i++) begin
            int thr, act, t;
            thr = int'($urandom_range(0, 65535)) - 32768;
            t   = ((i % 8) == 0) ? int'($urandom_range(0, 32767)) : int'($urandom_range(0, 400));
            act = thr + int'($urandom_range(0, 1600)) - 800;
            if (act > 32767) act = 32767;
            if (act < -32768) act = -32768;
            apply("R2 random", act, thr, t);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule